// File: doc/BRIEF.md
# Dual-register bidirectional bus transceiver

This block joins two 8-bit buses, A and B. Each direction has its own storage register, its own capture clock and its own source select. The forward path (A to B) drives bus B with either the live value on bus A or the contents of the A-side register. The reverse path (B to A) drives bus A with either the live value on bus B or the contents of the B-side register. The two direction enables have opposite polarities. The forward enable is active high and the reverse enable is active low. A register captures its bus on every rising edge of its clock, whatever the enable and select states are.

Each bus is split into three signals. One is an input vector that carries the resolved bus value. One is an output vector that carries the value the block would drive. The third is a single output-enable bit that covers all lanes. The surrounding logic, or the testbench, resolves these into a tri-state net. A bus-hold loop forms when both directions are enabled in live mode. In that loop each output reinforces its own input, so both buses keep their last value after every external driver lets go.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab` with `rst_n` high, the A-side register loads `a_in`. This happens whatever the values of `dir_ab_en`, `dir_ba_en_n`, `sel_ab` and `sel_ba`.
- R2: On every rising edge of `clk_ba` with `rst_n` high, the B-side register loads `b_in`. This also happens whatever the values of the enables and selects.
- R3: `b_oe` equals `dir_ab_en` (1 = drive bus B). `a_oe` equals the inverse of `dir_ba_en_n` (0 on `dir_ba_en_n` = drive bus A).
- R4: `b_out` carries `a_in` combinationally when `sel_ab` = 0. It carries the A-side register when `sel_ab` = 1. This holds whatever the value of `b_oe`.
- R5: `a_out` carries `b_in` combinationally when `sel_ba` = 0. It carries the B-side register when `sel_ba` = 1. This holds whatever the value of `a_oe`.
- R6: A rising edge of `clk_ab` while `rst_n` = 0 clears the A-side register to zero. A rising edge of `clk_ba` while `rst_n` = 0 clears the B-side register to zero.
- R7: With `dir_ab_en` = 0 and `dir_ba_en_n` = 1, both output enables are low (isolation). Both registers still capture their buses.
- R8: Set `dir_ab_en` = 1, `dir_ba_en_n` = 0, `sel_ab` = 0 and `sel_ba` = 0, then release all external drivers. Each resolved bus keeps the value it last carried.
- R9: Set `dir_ab_en` = 1, `dir_ba_en_n` = 0, `sel_ab` = 1 and `sel_ba` = 1. Bus B then shows the stored A data and bus A shows the stored B data, both at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Active-low reset, sampled by each capture clock |
| dir_ab_en | input | 1 | Forward enable, active high, gates driving of bus B |
| dir_ba_en_n | input | 1 | Reverse enable, active low, gates driving of bus A |
| sel_ab | input | 1 | Forward source: 0 live bus A, 1 stored A data |
| sel_ba | input | 1 | Reverse source: 0 live bus B, 1 stored B data |
| a_in | input | 8 | Resolved value of bus A |
| a_out | output | 8 | Value offered to bus A |
| a_oe | output | 1 | Drive enable for all lanes of bus A |
| b_in | input | 8 | Resolved value of bus B |
| b_out | output | 8 | Value offered to bus B |
| b_oe | output | 1 | Drive enable for all lanes of bus B |

## Verification
Only the outputs configured for stored mode expose the register contents. A wrong capture or a missed reset in a register shows on the opposite bus's output. It appears as soon as that direction's select is high and remains until the next capture edge of that register. A polarity slip in either enable appears at once on the corresponding `*_oe` port. On the resolved nets it breaks both isolation and the bus-hold loop, so a released bus drifts instead of keeping its value. The sweep loads both registers under every enable and select combination. It then changes the live buses so that the live value and the stored value differ at every check.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the dual-register transceiver.
// Assumes: one lane width is used for both buses.
package xcvr_pkg;
    localparam int XCVR_W = 8;

    // Source choice of one direction's output multiplexer.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
// Storage register for one direction.
// Loads its bus on every rising clock edge; clears synchronously on low rst_n.
// Assumes: rst_n is synchronised to clk by the surrounding logic.
module xcvr_store_reg #(
    parameter int W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the bus value, or clear under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xcvr_lane.sv
// Output path of one direction: source multiplexer plus enable polarity.
// ACTIVE_LOW selects the polarity of en_in that turns the driver on.
// Assumes: one enable bit covers every lane of the bus.
module xcvr_lane #(
    parameter int W          = xcvr_pkg::XCVR_W,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic         en_in,
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] data,
    output logic         oe
);
    import xcvr_pkg::*;

    src_sel_e src;

    // Choose the driven value: live opposite bus or stored register.
    always_comb begin
        src  = src_sel_e'(sel);
        data = (src == SRC_STORED) ? stored : live;
    end

    // Map the enable pin polarity onto a drive-high enable.
    generate
        if (ACTIVE_LOW) begin : g_low
            assign oe = ~en_in;
        end else begin : g_high
            assign oe = en_in;
        end
    endgenerate
endmodule

// File: rtl/dual_reg_xcvr.sv
// Dual-register bidirectional bus transceiver (top).
// Joins bus A and bus B. Each direction has its own register, capture clock,
// source select and enable (forward active high, reverse active low).
// Assumes: the buses are resolved outside; each bus appears here as in/out/oe.
module dual_reg_xcvr #(
    parameter int WIDTH = xcvr_pkg::XCVR_W
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             dir_ab_en,
    input  logic             dir_ba_en_n,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic [WIDTH-1:0] a_reg_q;
    logic [WIDTH-1:0] b_reg_q;

    xcvr_store_reg #(.W(WIDTH)) a_reg_i (
        .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(a_reg_q)
    );

    xcvr_store_reg #(.W(WIDTH)) b_reg_i (
        .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(b_reg_q)
    );

    xcvr_lane #(.W(WIDTH), .ACTIVE_LOW(1'b0)) fwd_i (
        .en_in(dir_ab_en), .sel(sel_ab), .live(a_in), .stored(a_reg_q),
        .data(b_out), .oe(b_oe)
    );

    xcvr_lane #(.W(WIDTH), .ACTIVE_LOW(1'b1)) rev_i (
        .en_in(dir_ba_en_n), .sel(sel_ba), .live(b_in), .stored(b_reg_q),
        .data(a_out), .oe(a_oe)
    );

    // Live-mode and isolation checks on the port values.
    always_comb begin
        if (rst_n) begin
            // R4
            rt_ab_chk: assert (sel_ab || b_out == a_in);
            // R5
            rt_ba_chk: assert (sel_ba || a_out == b_in);
            // R7
            iso_chk: assert (!(dir_ab_en == 1'b0 && dir_ba_en_n == 1'b1) || (!a_oe && !b_oe));
        end
    end

    // R1
    stored_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        rst_n |=> (!sel_ab || b_out == $past(a_in)));

    // R2
    stored_ba_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
        rst_n |=> (!sel_ba || a_out == $past(b_in)));
endmodule

// File: tb/dual_reg_xcvr_tb_top.sv
// Bench for dual_reg_xcvr. Each bus is resolved by a keeper register updated
// on the 125 MHz bench clock: the external driver wins, then the DUT, then hold.
module dual_reg_xcvr_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
    logic         dir_ab_en = 1'b0, dir_ba_en_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_net = '0, b_net = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ext_a_en = 1'b0, ext_b_en = 1'b0;
    logic [W-1:0] ext_a = '0, ext_b = '0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    dual_reg_xcvr #(.WIDTH(W)) dut_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
        .dir_ab_en(dir_ab_en), .dir_ba_en_n(dir_ba_en_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_net), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_net), .b_out(b_out), .b_oe(b_oe)
    );

    // Resolve each bus: external driver, else DUT driver, else keep.
    always @(posedge clk) begin
        a_net <= ext_a_en ? ext_a : (a_oe ? a_out : a_net);
        b_net <= ext_b_en ? ext_b : (b_oe ? b_out : b_net);
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ab();
        @(negedge clk); clk_ab = 1'b1;
        @(negedge clk); clk_ab = 1'b0;
    endtask

    task automatic pulse_ba();
        @(negedge clk); clk_ba = 1'b1;
        @(negedge clk); clk_ba = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pa, pb, qa, qb;
        // R6: reset clears both registers
        ext_a_en = 1'b1; ext_b_en = 1'b1; ext_a = 8'hA5; ext_b = 8'h5A;
        settle();
        pulse_ab(); pulse_ba();
        rst_n = 1'b1;
        sel_ab = 1'b1; sel_ba = 1'b1;
        settle();
        chk("R6 A reg after reset", b_out, 8'h00);
        chk("R6 B reg after reset", a_out, 8'h00);

        // Sweep all enable/select combinations with two data patterns each.
        for (int pat = 0; pat < 2; pat++) begin
            for (int c = 0; c < 16; c++) begin
                dir_ab_en   = c[3];
                dir_ba_en_n = c[2];
                sel_ab      = c[1];
                sel_ba      = c[0];
                pa = W'(c * 17 + 3 + pat * 64);
                pb = ~pa;
                qa = pa ^ 8'h3C;
                qb = pb ^ 8'hC3;
                ext_a = pa; ext_b = pb;
                settle();
                pulse_ab(); pulse_ba();
                ext_a = qa; ext_b = qb;
                settle();
                chk("R3 b_oe", {7'd0, b_oe}, {7'd0, c[3]});
                chk("R3 a_oe", {7'd0, a_oe}, {7'd0, ~c[2]});
                chk(c[1] ? "R1 stored A on b_out" : "R4 live A on b_out", b_out, c[1] ? pa : qa);
                chk(c[0] ? "R2 stored B on a_out" : "R5 live B on a_out", a_out, c[0] ? pb : qb);
                if (c[3:2] == 2'b01) begin
                    chk("R7 isolation oe", {6'd0, a_oe, b_oe}, 8'h00);
                    sel_ab = 1'b1; sel_ba = 1'b1;
                    settle();
                    chk("R7 A reg stored while isolated", b_out, pa);
                    chk("R7 B reg stored while isolated", a_out, pb);
                end
            end
        end

        // R8: bus hold with both directions live, released from each side.
        for (int side = 0; side < 2; side++) begin
            logic [W-1:0] v;
            v = side ? 8'hE7 : 8'h5A;
            dir_ab_en = 1'b1; dir_ba_en_n = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
            ext_a_en = (side == 0); ext_b_en = (side == 1);
            ext_a = v; ext_b = v;
            settle(); settle();
            ext_a_en = 1'b0; ext_b_en = 1'b0;
            ext_a = 8'h00; ext_b = 8'hFF;
            settle(); settle();
            chk("R8 bus A holds", a_net, v);
            chk("R8 bus B holds", b_net, v);
        end

        // R9: both directions show stored data at the same time.
        dir_ab_en = 1'b0; dir_ba_en_n = 1'b1;
        ext_a_en = 1'b1; ext_b_en = 1'b1; ext_a = 8'h3C; ext_b = 8'hC3;
        settle();
        pulse_ab(); pulse_ba();
        sel_ab = 1'b1; sel_ba = 1'b1; dir_ab_en = 1'b1; dir_ba_en_n = 1'b0;
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        settle(); settle();
        chk("R9 bus B shows stored A", b_net, 8'h3C);
        chk("R9 bus A shows stored B", a_net, 8'hC3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule